// File: doc/BRIEF.md
# Read-While-Write Bank Access Arbiter

This block gates every host access to a four-bank flash array model. It splits each incoming word address into a bank and a global sector index. It keeps a record of the one embedded program or erase that may be running, and it decides in a single registered step what happens to each request. A read is either granted to the array or answered with a status indication. A program or erase is either launched toward the timer stub or refused with an error code.

The array is asymmetric. The two outer banks each hold a run of small boot sectors plus large sectors, with the small run at the bottom of the first bank and at the top of the last bank. The two inner banks hold only large sectors. An erase can be put on hold. While it is held, reads and one program may go to any sector other than the one being erased. A per-sector protection mask and a low-supply input block program and erase.

Top module: `rww_bank_arbiter`

## Requirements
- R1: Banks 0..3 occupy ascending address ranges of 1+EDGE_LARGE, MID_LARGE, MID_LARGE and 1+EDGE_LARGE large units (2^LARGE_W words each). Sectors are numbered globally from address 0 upward. Bank 0 starts with N_SMALL=2^(LARGE_W-SMALL_W) small sectors of 2^SMALL_W words, and bank 3 ends with N_SMALL small sectors. Every other sector is one large unit. A granted read reports the decoded bank on rd_bank_o and the sector on rd_sector_o.
- R2: Op codes are read=0, program=1, erase=2, suspend=3, resume=4. A read to a bank that is not busy, and not to a suspended erase sector, raises rd_grant_o for one cycle after the request edge, with the same latency whether or not another bank is busy.
- R3: A read to the busy bank, or to the sector of a suspended erase, raises rd_status_o instead of rd_grant_o, for exactly one cycle.
- R4: active_bank_o shows the busy bank together with the bank of the read granted in that cycle, and never has more than two bits set.
- R5: A program or erase while an embedded operation is running is refused: err_o is high with err_code_o=3, and start_o stays low. An erase is also refused with code 3 while another erase is suspended.
- R6: ready_o goes low with start_o and goes high the cycle after done_i. After that, the formerly busy bank serves reads.
- R7: A program or erase to a sector whose bit in prot_mask_i is set is refused with err_code_o=2, for any combination of mask bits.
- R8: While vlow_i is high, every program and erase is refused with err_code_o=1. This code takes priority over codes 2 and 3.
- R9: Suspend halts a running erase: suspended_o is high, ready_o is high and busy_bank_o is clear. A program to another sector (same bank included) is launched. A program to the erasing sector is refused with err_code_o=4. Resume makes the erase busy again.
- R10: A suspend with no running erase, or a resume with no suspended erase or while a suspend-time program runs, is refused with err_code_o=5.
- R11: After reset, ready_o is high and busy_bank_o, suspended_o, rd_grant_o, rd_status_o, err_o and start_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Request op code |
| req_addr_i | input | ADDR_W | Word address |
| prot_mask_i | input | N_SECT | Per-sector protection, 1 = protected |
| vlow_i | input | 1 | Low-supply detect |
| done_i | input | 1 | Completion strobe from timer stub |
| ready_o | output | 1 | High when no embedded operation runs |
| busy_bank_o | output | 4 | One-hot busy bank |
| active_bank_o | output | 4 | Busy bank plus granted read bank |
| suspended_o | output | 1 | An erase is on hold |
| rd_grant_o | output | 1 | Read served from the array |
| rd_status_o | output | 1 | Read answered with status |
| rd_bank_o | output | 2 | Bank of the last read |
| rd_sector_o | output | SECT_W | Sector of the last read |
| start_o | output | 1 | Embedded operation launched |
| op_bank_o | output | 2 | Bank of the launched operation |
| err_o | output | 1 | Request refused |
| err_code_o | output | 3 | Refusal reason |

## Verification
The bench builds the block with SMALL_W=1, LARGE_W=3, EDGE_LARGE=3 and MID_LARGE=4. This gives a 128-word space of 16 large units and 22 sectors. With these values the first and last address of every bank can be named directly, and so can each of the four small sectors at both ends. The full decode, including both boot regions, is therefore checked against hand-derived sector numbers. The small sector count also keeps the protection mask short enough to set single bits and to set them together with the low-supply input, which exercises the refusal priority.

// File: rtl/rww_pkg.sv
package rww_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4
  } rww_op_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_LOWV      = 3'd1,
    ERR_PROT      = 3'd2,
    ERR_BUSY      = 3'd3,
    ERR_SUSP_SECT = 3'd4,
    ERR_SEQ       = 3'd5
  } rww_err_e;

  localparam int unsigned NUM_BANKS = 4;
endpackage

// File: rtl/rww_addr_decode.sv
module rww_addr_decode #(
  parameter int unsigned SMALL_W    = 12,
  parameter int unsigned LARGE_W    = 15,
  parameter int unsigned EDGE_LARGE = 15,
  parameter int unsigned MID_LARGE  = 48,
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned SECT_W     = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        bank_o,
  output logic [SECT_W-1:0] sector_o
);
  localparam int unsigned SUB_W     = LARGE_W - SMALL_W;
  localparam int unsigned LU_W      = ADDR_W - LARGE_W;
  localparam int unsigned N_SMALL   = 1 << SUB_W;
  localparam int unsigned EDGE_LU   = EDGE_LARGE + 1;
  localparam int unsigned EDGE_SECT = N_SMALL + EDGE_LARGE;

  function automatic int unsigned lu_base(input int unsigned b);
    case (b)
      0:       return 0;
      1:       return EDGE_LU;
      2:       return EDGE_LU + MID_LARGE;
      default: return EDGE_LU + 2 * MID_LARGE;
    endcase
  endfunction

  function automatic int unsigned sect_base(input int unsigned b);
    case (b)
      0:       return 0;
      1:       return EDGE_SECT;
      2:       return EDGE_SECT + MID_LARGE;
      default: return EDGE_SECT + 2 * MID_LARGE;
    endcase
  endfunction

  logic [LU_W-1:0]  lu;
  logic [SUB_W-1:0] sub;
  logic [3:0]       above;
  int unsigned      rel;
  int unsigned      sect;

  assign lu  = addr_i[ADDR_W-1:LARGE_W];
  assign sub = addr_i[LARGE_W-1:SMALL_W];

  // bank b starts at lu_base(b); bank 0 always matches
  assign above[0] = 1'b1;
  for (genvar b = 1; b < 4; b++) begin : g_bound
    assign above[b] = (32'(lu) >= lu_base(b));
  end

  always_comb begin
    if (above[3])      bank_o = 2'd3;
    else if (above[2]) bank_o = 2'd2;
    else if (above[1]) bank_o = 2'd1;
    else               bank_o = 2'd0;
  end

  always_comb begin
    rel = 32'(lu) - lu_base({30'd0, bank_o});
    case (bank_o)
      2'd0:    sect = (rel == 0) ? 32'(sub) : N_SMALL + rel - 1;
      2'd3:    sect = sect_base(3) + ((rel == EDGE_LARGE) ? EDGE_LARGE + 32'(sub) : rel);
      default: sect = sect_base({30'd0, bank_o}) + rel;
    endcase
    sector_o = SECT_W'(sect);
  end
endmodule

// File: rtl/rww_op_tracker.sv
module rww_op_tracker #(
  parameter int unsigned SECT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              done_i,
  input  logic [1:0]        bank_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              run_o,
  output logic [1:0]        run_bank_o,
  output logic              er_valid_o,
  output logic              er_susp_o,
  output logic [SECT_W-1:0] er_sector_o,
  output logic              pg_valid_o
);
  logic              er_valid_q, er_susp_q, pg_valid_q;
  logic [1:0]        er_bank_q, pg_bank_q;
  logic [SECT_W-1:0] er_sector_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      er_valid_q  <= 1'b0;
      er_susp_q   <= 1'b0;
      pg_valid_q  <= 1'b0;
      er_bank_q   <= '0;
      pg_bank_q   <= '0;
      er_sector_q <= '0;
    end else begin
      if (start_prog_i) begin
        pg_valid_q <= 1'b1;
        pg_bank_q  <= bank_i;
      end
      if (start_erase_i) begin
        er_valid_q  <= 1'b1;
        er_susp_q   <= 1'b0;
        er_bank_q   <= bank_i;
        er_sector_q <= sector_i;
      end
      if (suspend_i && !done_i) er_susp_q <= 1'b1;
      if (resume_i)             er_susp_q <= 1'b0;
      // completion retires whichever operation is running
      if (done_i) begin
        if (pg_valid_q) pg_valid_q <= 1'b0;
        else if (er_valid_q && !er_susp_q) er_valid_q <= 1'b0;
      end
    end
  end

  assign run_o       = pg_valid_q || (er_valid_q && !er_susp_q);
  assign run_bank_o  = pg_valid_q ? pg_bank_q : er_bank_q;
  assign er_valid_o  = er_valid_q;
  assign er_susp_o   = er_susp_q;
  assign er_sector_o = er_sector_q;
  assign pg_valid_o  = pg_valid_q;
endmodule

// File: rtl/rww_access_gate.sv
module rww_access_gate
  import rww_pkg::*;
#(
  parameter int unsigned SECT_W = 8
) (
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [1:0]        bank_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic              prot_hit_i,
  input  logic              vlow_i,
  input  logic              run_i,
  input  logic [1:0]        run_bank_i,
  input  logic              er_valid_i,
  input  logic              er_susp_i,
  input  logic [SECT_W-1:0] er_sector_i,
  input  logic              pg_valid_i,
  output logic              rd_grant_o,
  output logic              rd_status_o,
  output logic              start_prog_o,
  output logic              start_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output rww_err_e          err_code_o
);
  logic busy_hit, susp_hit;
  rww_op_e op;

  assign op       = rww_op_e'(req_op_i);
  assign busy_hit = run_i && (bank_i == run_bank_i);
  assign susp_hit = er_susp_i && (sector_i == er_sector_i);

  always_comb begin
    rd_grant_o    = 1'b0;
    rd_status_o   = 1'b0;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    suspend_o     = 1'b0;
    resume_o      = 1'b0;
    err_code_o    = ERR_NONE;
    if (req_valid_i) begin
      case (op)
        OP_READ: begin
          if (busy_hit || susp_hit) rd_status_o = 1'b1;
          else                      rd_grant_o  = 1'b1;
        end
        OP_PROG: begin
          if (vlow_i)          err_code_o = ERR_LOWV;
          else if (prot_hit_i) err_code_o = ERR_PROT;
          else if (run_i)      err_code_o = ERR_BUSY;
          else if (susp_hit)   err_code_o = ERR_SUSP_SECT;
          else                 start_prog_o = 1'b1;
        end
        OP_ERASE: begin
          if (vlow_i)                   err_code_o = ERR_LOWV;
          else if (prot_hit_i)          err_code_o = ERR_PROT;
          else if (run_i || er_valid_i) err_code_o = ERR_BUSY;
          else                          start_erase_o = 1'b1;
        end
        OP_SUSPEND: begin
          if (er_valid_i && !er_susp_i && !pg_valid_i) suspend_o = 1'b1;
          else                                         err_code_o = ERR_SEQ;
        end
        OP_RESUME: begin
          if (er_susp_i && !pg_valid_i) resume_o = 1'b1;
          else                          err_code_o = ERR_SEQ;
        end
        default: err_code_o = ERR_SEQ;
      endcase
    end
  end
endmodule

// File: rtl/rww_bank_arbiter.sv
module rww_bank_arbiter
  import rww_pkg::*;
#(
  parameter int unsigned SMALL_W    = 12,
  parameter int unsigned LARGE_W    = 15,
  parameter int unsigned EDGE_LARGE = 15,
  parameter int unsigned MID_LARGE  = 48,
  localparam int unsigned N_SMALL   = 1 << (LARGE_W - SMALL_W),
  localparam int unsigned TOTAL_LU  = 2 * (EDGE_LARGE + 1) + 2 * MID_LARGE,
  localparam int unsigned ADDR_W    = LARGE_W + $clog2(TOTAL_LU),
  localparam int unsigned N_SECT    = 2 * (N_SMALL + EDGE_LARGE) + 2 * MID_LARGE,
  localparam int unsigned SECT_W    = $clog2(N_SECT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [N_SECT-1:0] prot_mask_i,
  input  logic              vlow_i,
  input  logic              done_i,
  output logic              ready_o,
  output logic [3:0]        busy_bank_o,
  output logic [3:0]        active_bank_o,
  output logic              suspended_o,
  output logic              rd_grant_o,
  output logic              rd_status_o,
  output logic [1:0]        rd_bank_o,
  output logic [SECT_W-1:0] rd_sector_o,
  output logic              start_o,
  output logic [1:0]        op_bank_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);
  logic [1:0]        dec_bank;
  logic [SECT_W-1:0] dec_sector;
  logic              prot_hit;
  logic              run, er_valid, er_susp, pg_valid;
  logic [1:0]        run_bank;
  logic [SECT_W-1:0] er_sector;
  logic              g_grant, g_status, g_prog, g_erase, g_susp, g_resume;
  rww_err_e          g_err;

  rww_addr_decode #(
    .SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .EDGE_LARGE(EDGE_LARGE),
    .MID_LARGE(MID_LARGE), .ADDR_W(ADDR_W), .SECT_W(SECT_W)
  ) i_decode (
    .addr_i  (req_addr_i),
    .bank_o  (dec_bank),
    .sector_o(dec_sector)
  );

  assign prot_hit = prot_mask_i[dec_sector];

  rww_access_gate #(.SECT_W(SECT_W)) i_gate (
    .req_valid_i  (req_valid_i),
    .req_op_i     (req_op_i),
    .bank_i       (dec_bank),
    .sector_i     (dec_sector),
    .prot_hit_i   (prot_hit),
    .vlow_i       (vlow_i),
    .run_i        (run),
    .run_bank_i   (run_bank),
    .er_valid_i   (er_valid),
    .er_susp_i    (er_susp),
    .er_sector_i  (er_sector),
    .pg_valid_i   (pg_valid),
    .rd_grant_o   (g_grant),
    .rd_status_o  (g_status),
    .start_prog_o (g_prog),
    .start_erase_o(g_erase),
    .suspend_o    (g_susp),
    .resume_o     (g_resume),
    .err_code_o   (g_err)
  );

  rww_op_tracker #(.SECT_W(SECT_W)) i_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_prog_i (g_prog),
    .start_erase_i(g_erase),
    .suspend_i    (g_susp),
    .resume_i     (g_resume),
    .done_i       (done_i),
    .bank_i       (dec_bank),
    .sector_i     (dec_sector),
    .run_o        (run),
    .run_bank_o   (run_bank),
    .er_valid_o   (er_valid),
    .er_susp_o    (er_susp),
    .er_sector_o  (er_sector),
    .pg_valid_o   (pg_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_grant_o  <= 1'b0;
      rd_status_o <= 1'b0;
      rd_bank_o   <= '0;
      rd_sector_o <= '0;
      start_o     <= 1'b0;
      op_bank_o   <= '0;
      err_o       <= 1'b0;
      err_code_o  <= ERR_NONE;
    end else begin
      rd_grant_o  <= g_grant;
      rd_status_o <= g_status;
      start_o     <= g_prog || g_erase;
      err_o       <= (g_err != ERR_NONE);
      err_code_o  <= g_err;
      if (g_grant || g_status) begin
        rd_bank_o   <= dec_bank;
        rd_sector_o <= dec_sector;
      end
      if (g_prog || g_erase) op_bank_o <= dec_bank;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_vec
    assign busy_bank_o[b]   = run && (run_bank == 2'(b));
    assign active_bank_o[b] = busy_bank_o[b] || (rd_grant_o && (rd_bank_o == 2'(b)));
  end

  assign ready_o     = !run;
  assign suspended_o = er_susp;
endmodule

// File: rtl/rww_bank_arbiter_chk.sv
module rww_bank_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       vlow_i,
  input logic       done_i,
  input logic       ready_o,
  input logic [3:0] busy_bank_o,
  input logic [3:0] active_bank_o,
  input logic       rd_grant_o,
  input logic       rd_status_o,
  input logic [1:0] rd_bank_o,
  input logic       start_o
);
  AST_ACTIVE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(active_bank_o) <= 2); // R4
  AST_BUSY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_bank_o)); // R5
  AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ready_o) |=> ready_o); // R6
  AST_START_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !ready_o); // R6
  AST_GRANT_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_grant_o && rd_status_o)); // R3
  AST_GRANT_IDLE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_grant_o |-> !busy_bank_o[rd_bank_o]); // R2
  AST_LOWV_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vlow_i && req_valid_i) |=> !start_o); // R8
endmodule

bind rww_bank_arbiter rww_bank_arbiter_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .vlow_i       (vlow_i),
  .done_i       (done_i),
  .ready_o      (ready_o),
  .busy_bank_o  (busy_bank_o),
  .active_bank_o(active_bank_o),
  .rd_grant_o   (rd_grant_o),
  .rd_status_o  (rd_status_o),
  .rd_bank_o    (rd_bank_o),
  .start_o      (start_o)
);

// File: tb/test_rww_bank_arbiter.sv
`timescale 1ns/1ps
module test_rww_bank_arbiter;
  localparam int unsigned SMALL_W    = 1;
  localparam int unsigned LARGE_W    = 3;
  localparam int unsigned EDGE_LARGE = 3;
  localparam int unsigned MID_LARGE  = 4;
  localparam int unsigned N_SMALL    = 1 << (LARGE_W - SMALL_W);
  localparam int unsigned TOTAL_LU   = 2 * (EDGE_LARGE + 1) + 2 * MID_LARGE;
  localparam int unsigned ADDR_W     = LARGE_W + $clog2(TOTAL_LU);
  localparam int unsigned N_SECT     = 2 * (N_SMALL + EDGE_LARGE) + 2 * MID_LARGE;
  localparam int unsigned SECT_W     = $clog2(N_SECT);

  localparam logic [2:0] RD = 3'd0, PG = 3'd1, ER = 3'd2, SU = 3'd3, RS = 3'd4;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [2:0]        req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [N_SECT-1:0] prot_mask_i = '0;
  logic              vlow_i = 1'b0, done_i = 1'b0;
  logic              ready_o, suspended_o, rd_grant_o, rd_status_o, start_o, err_o;
  logic [3:0]        busy_bank_o, active_bank_o;
  logic [1:0]        rd_bank_o, op_bank_o;
  logic [SECT_W-1:0] rd_sector_o;
  logic [2:0]        err_code_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  rww_bank_arbiter #(
    .SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .EDGE_LARGE(EDGE_LARGE), .MID_LARGE(MID_LARGE)
  ) i_rww_bank_arbiter (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .prot_mask_i, .vlow_i, .done_i,
    .ready_o, .busy_bank_o, .active_bank_o, .suspended_o, .rd_grant_o, .rd_status_o,
    .rd_bank_o, .rd_sector_o, .start_o, .op_bank_o, .err_o, .err_code_o
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // drive at a falling edge, result is visible at the next falling edge
  task automatic req(input logic [2:0] op, input int a);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_addr_i  = ADDR_W'(a);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 ready", int'(ready_o), 1);
    chk("R11 busy", int'(busy_bank_o), 0);
    chk("R11 susp", int'(suspended_o), 0);
    chk("R11 grant", int'(rd_grant_o), 0);
    chk("R11 status", int'(rd_status_o), 0);
    chk("R11 err", int'(err_o), 0);
    chk("R11 start", int'(start_o), 0);
  endtask

  task automatic dec_one(input int a, input int bank, input int sect);
    req(RD, a);
    chk("R2 grant", int'(rd_grant_o), 1);
    chk("R1 bank", int'(rd_bank_o), bank);
    chk("R1 sector", int'(rd_sector_o), sect);
  endtask

  task automatic t_decode();
    dec_one(0, 0, 0);
    dec_one(6, 0, 3);
    dec_one(8, 0, 4);
    dec_one(31, 0, 6);
    dec_one(32, 1, 7);
    dec_one(63, 1, 10);
    dec_one(64, 2, 11);
    dec_one(95, 2, 14);
    dec_one(96, 3, 15);
    dec_one(119, 3, 17);
    dec_one(120, 3, 18);
    dec_one(127, 3, 21);
  endtask

  task automatic t_rww();
    req(PG, 40);
    chk("R6 start", int'(start_o), 1);
    chk("R6 ready low", int'(ready_o), 0);
    chk("R6 op bank", int'(op_bank_o), 1);
    chk("R5 busy bank", int'(busy_bank_o), 4'b0010);
    req(RD, 0);
    chk("R2 grant other bank", int'(rd_grant_o), 1);
    chk("R4 active", int'(active_bank_o), 4'b0011);
    req(RD, 45);
    chk("R3 status", int'(rd_status_o), 1);
    chk("R3 no grant", int'(rd_grant_o), 0);
    @(negedge clk_i);
    chk("R3 one cycle", int'(rd_status_o), 0);
    req(PG, 70);
    chk("R5 err", int'(err_o), 1);
    chk("R5 code", int'(err_code_o), 3);
    chk("R5 no start", int'(start_o), 0);
    req(ER, 100);
    chk("R5 erase code", int'(err_code_o), 3);
    pulse_done();
    chk("R6 ready high", int'(ready_o), 1);
    chk("R6 busy clear", int'(busy_bank_o), 0);
    req(RD, 45);
    chk("R6 read after done", int'(rd_grant_o), 1);
  endtask

  task automatic t_protect();
    prot_mask_i = '0;
    prot_mask_i[11] = 1'b1;
    prot_mask_i[3]  = 1'b1;
    req(PG, 64);
    chk("R7 prog code", int'(err_code_o), 2);
    chk("R7 no start", int'(start_o), 0);
    req(ER, 6);
    chk("R7 erase code", int'(err_code_o), 2);
    chk("R7 ready", int'(ready_o), 1);
    req(RD, 64);
    chk("R7 read ok", int'(rd_grant_o), 1);
    vlow_i = 1'b1;
    req(PG, 64);
    chk("R8 priority", int'(err_code_o), 1);
    prot_mask_i = '0;
    req(ER, 70);
    chk("R8 erase code", int'(err_code_o), 1);
    chk("R8 no start", int'(start_o), 0);
    chk("R8 ready", int'(ready_o), 1);
    vlow_i = 1'b0;
  endtask

  task automatic t_suspend();
    req(ER, 100);
    chk("R9 erase start", int'(start_o), 1);
    chk("R9 busy", int'(busy_bank_o), 4'b1000);
    req(SU, 0);
    chk("R9 suspended", int'(suspended_o), 1);
    chk("R9 ready", int'(ready_o), 1);
    chk("R9 not busy", int'(busy_bank_o), 0);
    req(RD, 100);
    chk("R9 erase sector status", int'(rd_status_o), 1);
    req(RD, 110);
    chk("R9 same bank read", int'(rd_grant_o), 1);
    req(PG, 100);
    chk("R9 prog erase sector", int'(err_code_o), 4);
    req(PG, 110);
    chk("R9 prog other sector", int'(start_o), 1);
    chk("R9 prog busy", int'(busy_bank_o), 4'b1000);
    req(RS, 0);
    chk("R10 resume in prog", int'(err_code_o), 5);
    pulse_done();
    chk("R9 prog done ready", int'(ready_o), 1);
    chk("R9 still suspended", int'(suspended_o), 1);
    req(RS, 0);
    chk("R9 resumed", int'(suspended_o), 0);
    chk("R9 erase busy again", int'(ready_o), 0);
    pulse_done();
    chk("R6 erase done", int'(ready_o), 1);
  endtask

  task automatic t_seq();
    req(SU, 0);
    chk("R10 suspend idle", int'(err_code_o), 5);
    req(RS, 0);
    chk("R10 resume idle", int'(err_code_o), 5);
    chk("R10 susp flag", int'(suspended_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_decode();
    t_rww();
    t_protect();
    t_suspend();
    t_seq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule